// File: doc/BRIEF.md
# DS3 Idle Signal Detector

This block watches a DS3 bit stream that has already been aligned upstream and decides, one M-frame at a time, whether the stream carries the idle signal. A framer ahead of it supplies the serial data and a strobe that marks which bit positions are overhead. It also supplies a strobe for the overhead positions that hold C-bits, the 1-based subframe number, a marker on the first bit of each M-frame, and an in-frame qualifier. The qualifier covers everything about the M, F and P alignment channels. This block does not inspect those channels itself.

Information bits must follow a repeating 1100 sequence. The sequence restarts with "11" on the first information bit after every overhead bit, so each 84-bit information block splits into 21 four-bit groups. The block counts errored groups across the whole frame. It also records whether any of the three C-bits of subframe 3 was a one. On the first bit of the next frame it updates a live, unlatched idle flag from those two results.

The control is a two-state machine. `ST_HUNT` is the state after reset, and also the state after the in-frame qualifier drops. No frame has been watched from its start in this state. `ST_TRACK` means the current frame has been followed from its first bit. Transition `T_LOCK` moves from `ST_HUNT` to `ST_TRACK` on a frame-start bit while in frame; it only arms the machine and does not update the flag. Transition `T_EVAL` stays in `ST_TRACK` on each frame-start bit and writes the verdict. Transition `T_LOSE` returns from `ST_TRACK` to `ST_HUNT` whenever the qualifier is low.

Top module: `idle_detector`

## Requirements
- R1: Within every run of information bits, the expected values follow the group pattern 1,1,0,0 in arrival order (parameter PATTERN = 4'b1100, leftmost bit first). The group phase returns to the first position after each overhead bit (`oh_strobe`=1).
- R2: A four-bit group counts as one errored group if one or more of its bits differs from the pattern, however many bits differ.
- R3: A frame followed from its first bit, with no more than 5 errored groups (ERR_LIMIT) and all subframe-3 C-bits zero, sets `idle_out` to 1 on the next frame-start bit.
- R4: A frame with 6 or more errored groups sets `idle_out` to 0 on the next frame-start bit.
- R5: A C-bit (`cbit_strobe`=1) equal to 1 while `sub_idx`=3 makes the frame non-idle. C-bits in other subframes, and all non-C overhead bits, do not affect the verdict.
- R6: `idle_out` changes only on the clock after a frame-start bit (`bit_en`=1 and `frame_start`=1), or when the in-frame qualifier falls. At all other times it holds its value.
- R7: While `in_frame` is 0, `idle_out` is 0 one clock later and the state is `ST_HUNT`. A frame during which `in_frame` fell is never declared idle. The first frame-start bit after `in_frame` returns only arms the machine.
- R8: The per-frame errored-group count saturates at ERR_LIMIT+1 and is cleared by every frame-start bit.
- R9: After reset `idle_out` is 0. The first frame-start bit after reset only arms the machine and leaves `idle_out` at 0.
- R10: Cycles with `bit_en`=0 have no effect, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | A stream bit is present this cycle |
| bit_data | input | 1 | Stream bit value |
| oh_strobe | input | 1 | The current bit is an overhead bit |
| cbit_strobe | input | 1 | The current overhead bit is a C-bit |
| sub_idx | input | SUB_W | Subframe number of the current bit, 1 to 7 |
| frame_start | input | 1 | The current bit is the first overhead bit of an M-frame |
| in_frame | input | 1 | Upstream alignment is valid |
| idle_out | output | 1 | Idle verdict for the most recent complete frame |

## Verification
The assertions assume a well-formed stream from the framer. `frame_start` only ever accompanies an overhead bit that is not a C-bit. Each information run is a whole number of four-bit groups. Under these assumptions the frame-start cycle can never also be a group-completion cycle or a C-bit cycle, so the counters are exactly zero after it. The bench builds every frame from the 7 x 8 x 85 bit layout, with C-bits on blocks 2, 4 and 6 of each subframe. It places random idle cycles with random contents only where `bit_en` is low. It injects errors by corrupting a random nonzero subset of bits inside chosen whole groups, so it never produces a malformed frame.

// File: rtl/idle_det_pkg.sv
package idle_det_pkg;
    typedef enum logic [0:0] {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } det_state_t;
endpackage

// File: rtl/idle_grp_check.sv
// Tracks the position inside a pattern group and flags each finished group
// that had at least one mismatching bit.
module idle_grp_check #(
    parameter int                 GROUP_LEN = 4,
    parameter logic [GROUP_LEN-1:0] PATTERN = 4'b1100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic info_en,
    input  logic oh_en,
    input  logic data,
    output logic grp_err
);
    localparam int PH_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP_LEN - 1);

    logic [PH_W-1:0]      phase;
    logic                 bad_so_far;
    logic [GROUP_LEN-1:0] pat_sh;
    logic                 mism;
    logic                 at_last;

    always_comb begin
        pat_sh  = PATTERN << phase;
        mism    = data ^ pat_sh[GROUP_LEN-1];
        at_last = (phase == PH_LAST);
        grp_err = info_en && at_last && (bad_so_far || mism);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || oh_en) begin
            phase      <= '0;
            bad_so_far <= 1'b0;
        end else if (info_en) begin
            if (at_last) begin
                phase      <= '0;
                bad_so_far <= 1'b0;
            end else begin
                phase      <= phase + 1'b1;
                bad_so_far <= bad_so_far | mism;
            end
        end
    end
endmodule

// File: rtl/idle_err_count.sv
// Saturating per-frame count of errored groups.
module idle_err_count #(
    parameter int ERR_LIMIT = 5,
    parameter int CNT_W     = $clog2(ERR_LIMIT + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             over
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(ERR_LIMIT + 1);

    assign over = (cnt > CNT_W'(ERR_LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (inc && cnt != SAT)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/idle_cbit_check.sv
// Remembers whether any C-bit of the chosen subframe was a one this frame.
module idle_cbit_check #(
    parameter int SUB_W = 3,
    parameter int C_SUB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cbit_en,
    input  logic [SUB_W-1:0] sub_idx,
    input  logic             data,
    output logic             c_bad
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            c_bad <= 1'b0;
        else if (cbit_en && sub_idx == SUB_W'(C_SUB) && data)
            c_bad <= 1'b1;
    end
endmodule

// File: rtl/idle_detector.sv
module idle_detector
    import idle_det_pkg::*;
#(
    parameter int                 GROUP_LEN = 4,
    parameter logic [GROUP_LEN-1:0] PATTERN = 4'b1100,
    parameter int                 ERR_LIMIT = 5,
    parameter int                 SUB_W     = 3,
    parameter int                 C_SUB     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_data,
    input  logic             oh_strobe,
    input  logic             cbit_strobe,
    input  logic [SUB_W-1:0] sub_idx,
    input  logic             frame_start,
    input  logic             in_frame,
    output logic             idle_out
);
    localparam int CNT_W = $clog2(ERR_LIMIT + 2);

    det_state_t       state, state_nx;
    logic             info_en, oh_en, frm_edge;
    logic             grp_err;
    logic [CNT_W-1:0] err_cnt;
    logic             err_over;
    logic             c_bad;
    logic             verdict;

    assign info_en  = bit_en && !oh_strobe;
    assign oh_en    = bit_en && oh_strobe;
    assign frm_edge = bit_en && frame_start;
    assign verdict  = !err_over && !c_bad;

    idle_grp_check #(.GROUP_LEN(GROUP_LEN), .PATTERN(PATTERN)) grp_i (
        .clk(clk), .rst_n(rst_n), .info_en(info_en), .oh_en(oh_en),
        .data(bit_data), .grp_err(grp_err)
    );

    idle_err_count #(.ERR_LIMIT(ERR_LIMIT), .CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clear(frm_edge), .inc(grp_err),
        .cnt(err_cnt), .over(err_over)
    );

    idle_cbit_check #(.SUB_W(SUB_W), .C_SUB(C_SUB)) cbit_i (
        .clk(clk), .rst_n(rst_n), .clear(frm_edge),
        .cbit_en(oh_en && cbit_strobe), .sub_idx(sub_idx),
        .data(bit_data), .c_bad(c_bad)
    );

    // next-state logic: T_LOCK, T_EVAL, T_LOSE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:  if (in_frame && frm_edge) state_nx = ST_TRACK;
            ST_TRACK: if (!in_frame)            state_nx = ST_HUNT;
            default:                            state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n || !in_frame)
            idle_out <= 1'b0;
        else if (frm_edge && state == ST_TRACK)
            idle_out <= verdict;
    end
endmodule

// File: rtl/idle_detector_chk.sv
module idle_detector_chk
    import idle_det_pkg::*;
#(
    parameter int ERR_LIMIT = 5,
    parameter int CNT_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             frame_start,
    input logic             in_frame,
    input logic             idle_out,
    input logic [CNT_W-1:0] err_cnt,
    input logic             c_bad,
    input det_state_t       state
);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && !(bit_en && frame_start)) |=> $stable(idle_out));

    p_force_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |=> (!idle_out && state == ST_HUNT));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= CNT_W'(ERR_LIMIT + 1));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_start) |=> (err_cnt == '0 && !c_bad));

    p_rise_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_out) |-> $past(!c_bad && err_cnt <= CNT_W'(ERR_LIMIT)
                                  && state == ST_TRACK));

    p_hunt_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && !idle_out) |=> !idle_out);
endmodule

bind idle_detector idle_detector_chk #(.ERR_LIMIT(ERR_LIMIT), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .in_frame(in_frame), .idle_out(idle_out), .err_cnt(err_cnt),
    .c_bad(c_bad), .state(state)
);

// File: tb/idle_detector_tb_top.sv
`timescale 1ns/1ps
module idle_detector_tb_top;
    localparam int GROUPS = 7 * 8 * 21;
    localparam logic [3:0] PAT = 4'b1100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, bit_data = 1'b0, oh_strobe = 1'b0, cbit_strobe = 1'b0;
    logic [2:0] sub_idx = 3'd1;
    logic       frame_start = 1'b0, in_frame = 1'b1;
    logic       idle_out;

    int n_tests = 0, n_fail = 0;
    bit armed = 1'b0, cur_idle = 1'b0, last_verdict = 1'b0;
    string last_tag = "R9";

    always #5 clk = ~clk;

    idle_detector dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_data(bit_data),
        .oh_strobe(oh_strobe), .cbit_strobe(cbit_strobe), .sub_idx(sub_idx),
        .frame_start(frame_start), .in_frame(in_frame), .idle_out(idle_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: idle_out=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit frame_verdict(input int n_err, input bit cbad, input bit drop);
        return (n_err <= 5) && !cbad && !drop;
    endfunction

    // one stream bit, possibly preceded by a junk cycle with bit_en low (R10)
    task automatic drive_bit(input bit d, input bit oh, input bit cb,
                             input int sub, input bit fs);
        if ($urandom % 8 == 0) begin
            bit_en = 1'b0; bit_data = 1'($urandom); oh_strobe = 1'($urandom);
            cbit_strobe = 1'($urandom); frame_start = 1'($urandom);
            sub_idx = 3'd3;
            @(negedge clk);
        end
        bit_en = 1'b1; bit_data = d; oh_strobe = oh; cbit_strobe = cb;
        sub_idx = 3'(sub); frame_start = fs;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic boundary();
        drive_bit(1'($urandom), 1'b1, 1'b0, 1, 1'b1);
        if (armed) cur_idle = last_verdict;
        check(idle_out == cur_idle, armed ? last_tag : "R9 R7 arm", idle_out, cur_idle);
        armed = in_frame;
    endtask

    task automatic send_frame(input int n_err, input bit cbad, input bit drop);
        bit emap [GROUPS];
        int placed = 0, gi = 0;
        int lim = (n_err > GROUPS) ? GROUPS : n_err;
        int cpos = 2 + 2 * int'($urandom % 3);
        for (int i = 0; i < GROUPS; i++) emap[i] = 1'b0;
        while (placed < lim) begin
            int idx = int'($urandom % GROUPS);
            if (!emap[idx]) begin emap[idx] = 1'b1; placed++; end
        end
        boundary();
        for (int sub = 1; sub <= 7; sub++) begin
            for (int blk = 0; blk < 8; blk++) begin
                bit cb = (blk == 2 || blk == 4 || blk == 6);
                if (!(sub == 1 && blk == 0)) begin
                    bit d = 1'($urandom);
                    if (cb && sub == 3) d = cbad && (blk == cpos);
                    if (drop && sub == 4 && blk == 0) begin
                        in_frame = 1'b0; armed = 1'b0; cur_idle = 1'b0;
                    end
                    if (drop && sub == 6 && blk == 0) in_frame = 1'b1;
                    drive_bit(d, 1'b1, cb, sub, 1'b0);
                    if (sub == 5 && blk == 0 && drop)
                        check(idle_out == 1'b0, "R7 forced low", idle_out, 0);
                    if (sub == 4 && blk == 1 && !drop)
                        check(idle_out == cur_idle, "R6 hold mid-frame", idle_out, cur_idle);
                end
                for (int g = 0; g < 21; g++) begin
                    logic [3:0] mask = emap[gi] ? 4'(($urandom % 15) + 1) : 4'd0;
                    gi++;
                    for (int b = 0; b < 4; b++)
                        drive_bit(PAT[3-b] ^ mask[3-b], 1'b0, 1'b0, sub, 1'b0);
                end
            end
        end
        last_verdict = frame_verdict(n_err, cbad, drop);
        if (drop)             last_tag = "R7 lost frame";
        else if (cbad)        last_tag = "R5 C-bit";
        else if (n_err > 5)   last_tag = (n_err > 6) ? "R4 R8 many errors" : "R4 six errors";
        else                  last_tag = (n_err > 0) ? "R3 R2 R1 tolerated" : "R3 R1 clean";
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: idle_out=%0d expected=done", idle_out);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int ne [8] = '{0, 5, 6, 0, 1, 0, 0, 200};
        bit cbv[8] = '{0, 0, 0, 1, 0, 0, 0, 0};
        bit drv[8] = '{0, 0, 0, 0, 0, 1, 0, 0};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle_out == 1'b0, "R9 reset", idle_out, 0);
        for (int f = 0; f < 8; f++) send_frame(ne[f], cbv[f], drv[f]);
        for (int f = 0; f < 6; f++)
            send_frame(int'($urandom % 9), ($urandom % 6) == 0, 1'b0);
        boundary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule